// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is a two-address configuration port for a peripheral controller. A host reaches it over a small I/O bus. The bus has one address bit that picks the index slot or the data slot, read and write strobes, and byte-wide data. After reset the port is closed. A host opens it by writing the open key byte (0x87) to the index slot on two writes in a row. It closes the port by writing the close key byte (0xAA) to the same slot.

While the port is open, a write to the index slot picks a register. The data slot then reads or writes that register. Index 0x07 holds the logical-device number. Indices 0x20 to 0x24 return fixed identification bytes:

| Index | Content |
|-------|---------|
| 0x20 | chip code, high byte |
| 0x21 | chip code, low byte |
| 0x22 | revision byte |
| 0x23 | vendor code, high byte (default 0x1934) |
| 0x24 | vendor code, low byte |

Indices from 0x30 upward belong to the device that is currently selected. For those, the port passes each access to an attached device register block. It supplies that block with the device number, the index and strobes. Device number 0x06 is, for example, the general-purpose I/O function.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is closed (`cfgOpen`=0), the index register is 0x00 and the device select (`devSel`) is 0x00.
- R2: `cfgOpen` rises in the cycle after the second of two back-to-back index-slot writes of 0x87.
- R3: An index-slot write of any value other than 0x87 between the two key bytes restarts the unlock sequence. Data-slot writes do not disturb the sequence.
- R4: While open, an index-slot write of 0xAA closes the port and leaves the index register unchanged. Any other index-slot write loads the index register.
- R5: While closed, a read of either slot returns 0xFF. Data-slot writes and non-key index writes change no state and raise no device strobe.
- R6: While open, a read of the index slot (busAddr=0) returns the index register.
- R7: While open, data-slot writes with index 0x07 load the device select. Reads with index 0x07 return it, and `devSel` always shows it.
- R8: While open, data reads at indices 0x20, 0x21, 0x22, 0x23 and 0x24 return, in that order: chip code high byte, chip code low byte, revision, vendor code high byte, vendor code low byte. Writes to these indices are ignored.
- R9: While open and with index at 0x30 or above, a data write asserts `devWr` in the same cycle, and a data read asserts `devRd` and returns `devRdata`. `devIdx` carries the index and `devWdata` carries the bus byte.
- R10: While open, data reads at any other index return 0x00, and data writes there have no effect.
- R11: `busRdata` is 0x00 in any cycle without `busRd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 1 | Slot select: 0 index, 1 data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Read byte, combinational |
| cfgOpen | output | 1 | Configuration mode active |
| devSel | output | 8 | Selected logical-device number |
| devIdx | output | 8 | Current register index |
| devWdata | output | 8 | Byte for the device block |
| devWr | output | 1 | Device register write strobe |
| devRd | output | 1 | Device register read strobe |
| devRdata | input | 8 | Device register read byte |

## Verification
A key-sequence state that is wrong shows up at `cfgOpen` one cycle after the offending index write. It also flips every read between 0xFF and real data in that same cycle. A wrong index or device-select register stays hidden until the next data access. At that access it appears at once as a wrong read byte, a missing or spurious `devWr`/`devRd`, or a mismatch on `devIdx`/`devSel`. The bench compares every output against its model on every cycle, so a divergence is caught in the first cycle it becomes visible.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } keyState_t;

  typedef struct packed {
    logic portOpen;
    logic idxLoad;
    logic ldsLoad;
    logic fwdWr;
    logic fwdRd;
  } portStrobe_t;
endpackage

// File: rtl/cfg_key_ctrl.sv
module cfg_key_ctrl
  import cfg_port_pkg::*;
#(
  parameter logic [BYTE_W-1:0] KEY_OPEN  = 8'h87,
  parameter logic [BYTE_W-1:0] KEY_CLOSE = 8'hAA,
  parameter logic [BYTE_W-1:0] LDS_IDX   = 8'h07,
  parameter logic [BYTE_W-1:0] DEV_BASE  = 8'h30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] curIdx,
  output portStrobe_t       stb
);
  keyState_t state, stateNext;
  logic idxWr, datWr, isOpen, devRange;

  assign idxWr    = busWr && !busAddr;
  assign datWr    = busWr && busAddr;
  assign isOpen   = (state == ST_OPEN);
  assign devRange = (curIdx >= DEV_BASE);

  always_comb begin
    stateNext = state;
    if (idxWr) begin
      case (state)
        ST_LOCKED: if (busWdata == KEY_OPEN) stateNext = ST_HALF;
        ST_HALF:   stateNext = (busWdata == KEY_OPEN) ? ST_OPEN : ST_LOCKED;
        ST_OPEN:   if (busWdata == KEY_CLOSE) stateNext = ST_LOCKED;
        default:   stateNext = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_LOCKED;
    else       state <= stateNext;
  end

  always_comb begin
    stb.portOpen = isOpen;
    stb.idxLoad  = isOpen && idxWr && (busWdata != KEY_CLOSE);
    stb.ldsLoad  = isOpen && datWr && (curIdx == LDS_IDX);
    stb.fwdWr    = isOpen && datWr && devRange;
    stb.fwdRd    = isOpen && busRd && busAddr && devRange;
  end

  // R2: opening only ever follows an index write of the open key
  assert_open_after_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.portOpen) |-> $past(busWr && !busAddr && busWdata == KEY_OPEN));

  // R4: the close key shuts an open port on the next cycle
  assert_close_key_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.portOpen && busWr && !busAddr && busWdata == KEY_CLOSE) |=> !stb.portOpen);

  // R3: a foreign index byte while half-unlocked never opens the port
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALF && busWr && !busAddr && busWdata != KEY_OPEN) |=> !stb.portOpen);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
#(
  parameter logic [15:0]       CHIP_ID   = 16'h5A21,
  parameter logic [BYTE_W-1:0] REV_ID    = 8'h03,
  parameter logic [15:0]       VENDOR_ID = 16'h1934,
  parameter logic [BYTE_W-1:0] LDS_IDX   = 8'h07,
  parameter logic [BYTE_W-1:0] ID_BASE   = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       stb,
  input  logic              busAddr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] devRdata,
  output logic [BYTE_W-1:0] curIdx,
  output logic [BYTE_W-1:0] ldsReg,
  output logic [BYTE_W-1:0] busRdata
);
  localparam int ID_N     = 5;
  localparam int ID_SLOTS = 8;
  localparam int OFF_W    = $clog2(ID_SLOTS);

  function automatic logic [BYTE_W-1:0] idLookup(input int k);
    case (k)
      0:       return CHIP_ID[15:8];
      1:       return CHIP_ID[7:0];
      2:       return REV_ID;
      3:       return VENDOR_ID[15:8];
      4:       return VENDOR_ID[7:0];
      default: return '0;
    endcase
  endfunction

  logic [BYTE_W-1:0] idBytes [ID_SLOTS];
  for (genvar g = 0; g < ID_SLOTS; g++) begin : gIdRom
    if (g < ID_N) begin : gUsed
      assign idBytes[g] = idLookup(g);
    end else begin : gSpare
      assign idBytes[g] = '0;
    end
  end

  logic [BYTE_W-1:0] idOff;
  logic              inIdRange;
  logic [BYTE_W-1:0] dataByte;

  assign idOff     = curIdx - ID_BASE;
  assign inIdRange = (curIdx >= ID_BASE) && (idOff < BYTE_W'(ID_N));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx <= '0;
      ldsReg <= '0;
    end else begin
      if (stb.idxLoad) curIdx <= busWdata;
      if (stb.ldsLoad) ldsReg <= busWdata;
    end
  end

  always_comb begin
    if (stb.fwdRd)                 dataByte = devRdata;
    else if (curIdx == LDS_IDX)    dataByte = ldsReg;
    else if (inIdRange)            dataByte = idBytes[idOff[OFF_W-1:0]];
    else                           dataByte = '0;
  end

  always_comb begin
    if (!busRd)             busRdata = '0;
    else if (!stb.portOpen) busRdata = '1;
    else if (!busAddr)      busRdata = curIdx;
    else                    busRdata = dataByte;
  end

  // R7: the device select only changes on a select-register write
  assert_lds_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldsLoad |=> $stable(ldsReg));

  // R5: a closed port reads as all ones
  assert_locked_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.portOpen && busRd) |-> busRdata == '1);

  // R4: the index register only changes while the port is open
  assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.portOpen |=> $stable(curIdx));
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID   = 16'h5A21,
  parameter logic [7:0]  REV_ID    = 8'h03,
  parameter logic [15:0] VENDOR_ID = 16'h1934,
  parameter logic [7:0]  LDS_IDX   = 8'h07,
  parameter logic [7:0]  ID_BASE   = 8'h20,
  parameter logic [7:0]  DEV_BASE  = 8'h30,
  parameter logic [7:0]  KEY_OPEN  = 8'h87,
  parameter logic [7:0]  KEY_CLOSE = 8'hAA
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       cfgOpen,
  output logic [7:0] devSel,
  output logic [7:0] devIdx,
  output logic [7:0] devWdata,
  output logic       devWr,
  output logic       devRd,
  input  logic [7:0] devRdata
);
  portStrobe_t       stb;
  logic [BYTE_W-1:0] curIdx;

  cfg_key_ctrl #(
    .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE),
    .LDS_IDX(LDS_IDX), .DEV_BASE(DEV_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .curIdx(curIdx), .stb(stb)
  );

  cfg_regfile #(
    .CHIP_ID(CHIP_ID), .REV_ID(REV_ID), .VENDOR_ID(VENDOR_ID),
    .LDS_IDX(LDS_IDX), .ID_BASE(ID_BASE)
  ) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .busRd(busRd),
    .busWdata(busWdata), .devRdata(devRdata), .curIdx(curIdx),
    .ldsReg(devSel), .busRdata(busRdata)
  );

  assign cfgOpen  = stb.portOpen;
  assign devIdx   = curIdx;
  assign devWdata = busWdata;
  assign devWr    = stb.fwdWr;
  assign devRd    = stb.fwdRd;

  // R9: device strobes only for device-range indices
  assert_dev_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (devWr || devRd) |-> (cfgOpen && devIdx >= DEV_BASE));

  // R11: idle bus reads as zero
  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> busRdata == 8'h00);
endmodule

// File: tb/keyed_cfg_port_bench.sv
module keyed_cfg_port_bench;
  localparam logic [15:0] B_CHIP = 16'h5A21;
  localparam logic [7:0]  B_REV  = 8'h03;
  localparam logic [15:0] B_VEND = 16'h1934;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busAddr = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata, devSel, devIdx, devWdata, devRdata;
  logic cfgOpen, devWr, devRd;

  int checks = 0;
  int fails  = 0;

  // model state
  int mState = 0;
  int mIdx   = 0;
  int mLds   = 0;

  always #5 clk = ~clk;

  assign devRdata = devIdx ^ {devSel[3:0], 4'hA};

  keyed_cfg_port #(.CHIP_ID(B_CHIP), .REV_ID(B_REV)) u_keyed_cfg_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .cfgOpen(cfgOpen),
    .devSel(devSel), .devIdx(devIdx), .devWdata(devWdata), .devWr(devWr),
    .devRd(devRd), .devRdata(devRdata)
  );

  function automatic int modelRead(input bit a, input bit r);
    int v;
    if (!r) return 0;
    if (mState != 2) return 8'hFF;
    if (!a) return mIdx;
    if (mIdx >= 8'h30) begin
      v = (mIdx ^ (((mLds & 15) << 4) | 10)) & 255;
      return v;
    end
    case (mIdx)
      8'h07: return mLds;
      8'h20: return B_CHIP[15:8];
      8'h21: return B_CHIP[7:0];
      8'h22: return B_REV;
      8'h23: return B_VEND[15:8];
      8'h24: return B_VEND[7:0];
      default: return 0;
    endcase
  endfunction

  task automatic compare(input string tag);
    int expRd;
    bit expOpen, expWr, expRdS;
    expOpen = (mState == 2);
    expRd   = modelRead(busAddr, busRd);
    expWr   = expOpen && busWr && busAddr && (mIdx >= 8'h30);
    expRdS  = expOpen && busRd && busAddr && (mIdx >= 8'h30);
    checks++;
    if (int'(busRdata) != expRd || cfgOpen != expOpen || devWr != expWr ||
        devRd != expRdS || int'(devIdx) != mIdx || int'(devSel) != mLds ||
        devWdata != busWdata) begin
      fails++;
      $display("FAIL %s: rd=%h open=%b wr=%b rdS=%b idx=%h sel=%h expected rd=%h open=%b wr=%b rdS=%b idx=%h sel=%h",
               tag, busRdata, cfgOpen, devWr, devRd, devIdx, devSel,
               expRd[7:0], expOpen, expWr, expRdS, mIdx[7:0], mLds[7:0]);
    end
  endtask

  task automatic modelStep();
    if (busWr && !busAddr) begin
      case (mState)
        0: if (busWdata == 8'h87) mState = 1;
        1: mState = (busWdata == 8'h87) ? 2 : 0;
        default: if (busWdata == 8'hAA) mState = 0; else mIdx = busWdata;
      endcase
    end else if (busWr && busAddr && mState == 2 && mIdx == 8'h07) begin
      mLds = busWdata;
    end
  endtask

  task automatic cyc(input bit a, input bit w, input bit r, input logic [7:0] d,
                     input string tag);
    @(negedge clk);
    busAddr = a; busWr = w; busRd = r; busWdata = d;
    #1;
    compare(tag);
    @(posedge clk);
    modelStep();
  endtask

  task automatic idxW(input logic [7:0] d, input string tag); cyc(1'b0, 1'b1, 1'b0, d, tag); endtask
  task automatic datW(input logic [7:0] d, input string tag); cyc(1'b1, 1'b1, 1'b0, d, tag); endtask
  task automatic datR(input string tag); cyc(1'b1, 1'b0, 1'b1, 8'h00, tag); endtask
  task automatic idxR(input string tag); cyc(1'b0, 1'b0, 1'b1, 8'h00, tag); endtask
  task automatic idle(input string tag); cyc(1'b0, 1'b0, 1'b0, 8'h00, tag); endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    idle("R1 reset state");
    idle("R11 idle bus");
    // closed port
    idxR("R5 closed index read");
    datR("R5 closed data read");
    idxW(8'h07, "R5 closed index write");
    datW(8'h55, "R5 closed data write");
    datR("R5 closed read after write");
    // broken sequence
    idxW(8'h87, "R3 first key");
    idxW(8'h12, "R3 foreign byte");
    idle("R3 still closed");
    idxW(8'h87, "R3 key again");
    datW(8'h33, "R3 data write between keys");
    idxW(8'h87, "R2 second key");
    idle("R2 open");
    // index and select
    idxW(8'h07, "R4 index load");
    idxR("R6 index read");
    datW(8'h06, "R7 select write");
    datR("R7 select read");
    // identification
    for (int k = 0; k < 5; k++) begin
      idxW(8'h20 + 8'(k), "R8 id index");
      datR("R8 id read");
      datW(8'hEE, "R8 id write ignored");
      datR("R8 id read after write");
    end
    // unused index
    idxW(8'h10, "R10 unused index");
    datW(8'h44, "R10 unused write");
    datR("R10 unused read");
    idxW(8'h2F, "R10 below device range");
    datR("R10 read");
    // device range
    idxW(8'h30, "R9 device base");
    datW(8'h3C, "R9 device write");
    datR("R9 device read");
    idxW(8'hF0, "R9 high index");
    datW(8'hC3, "R9 device write high");
    datR("R9 device read high");
    idxR("R6 index read high");
    // close
    idxW(8'hAA, "R4 close key");
    idxR("R4 closed read");
    datW(8'h99, "R5 closed device write");
    datR("R5 closed data read");
    // reopen
    idxW(8'h87, "R2 reopen first");
    idxW(8'h87, "R2 reopen second");
    idxR("R4 index kept");
    idxW(8'h07, "R7 select index");
    datR("R7 select kept");
    datW(8'h0B, "R7 select change");
    idxW(8'h31, "R9 device index");
    datR("R9 read with new select");
    idxW(8'h87, "R4 key as index");
    idxR("R6 read key index");
    idle("R11 final idle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule